// File: doc/BRIEF.md
# Watchdog Timer with Control Register

This block is a watchdog counter. It sends a non-maskable interrupt request to the CPU when software fails to restart it in time. It counts a low-frequency tick. The tick is a one-cycle enable in the system clock domain, not a separate clock. Software reaches the block through one byte-wide control register on a simple bus. The bus has an address-match select, a write strobe, a read strobe, 8-bit write data and registered 8-bit read data.

The timeout is fixed at build time by the parameter `TIMEOUT_TICKS`, which must be a power of two and at least 8. The counter has two stages:
- A free-running fine prescaler that counts one quarter of the timeout.
- A 2-bit coarse stage that counts prescaler carries.

A restart clears only the coarse stage. The prescaler phase is left as it is, so the time from a restart to the interrupt lies between three quarters and all of the nominal timeout. The enable bit is set at reset, so the watchdog runs from power-up until software turns it off. The remaining bits of the register are plain storage for neighbouring logic.

Top module: `wdog_unit`

## Requirements
- R1: After reset, the interrupt output is low and a read of the control register returns 0x80.
- R2: Bit 7 of the control register is the enable bit. It can be written and read back, and its reset value is 1.
- R3: Bit 2 is the restart command. It is write-only and always reads as 0, including after 0xFF is written.
- R4: Bits 6..3 and 1..0 store the written value and read it back unchanged. They have no effect on counting.
- R5: While enabled, each tick advances the prescaler modulo Q = TIMEOUT_TICKS/4. Each prescaler wrap advances the 2-bit coarse stage. Counting from reset, the first interrupt follows exactly TIMEOUT_TICKS ticks.
- R6: The interrupt output is a pulse one clock wide. It appears in the clock cycle after the tick that wraps the coarse stage from 3 to 0. Counting continues, so the next interrupt follows TIMEOUT_TICKS ticks later.
- R7: Writing 1 to bit 2 clears only the coarse stage. If the prescaler holds phase p at the restart, the interrupt follows after exactly TIMEOUT_TICKS − p ticks. This lies between 3·TIMEOUT_TICKS/4 + 1 and TIMEOUT_TICKS ticks.
- R8: Writing 0 to bit 2 does not change the counting.
- R9: While the enable bit is 0, both stages hold their values and no interrupt is raised. After the enable bit is set again, counting resumes from the held state.
- R10: If a restart write and a timeout-producing tick fall in the same cycle, the restart wins and no interrupt is raised.
- R11: Read data appears in the cycle after a read with the select high. Writes without the select high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable from the low-frequency time base |
| bus_sel | input | 1 | Address match for the control register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| nmi_pulse | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with TIMEOUT_TICKS = 32, which gives a prescaler of 8 ticks. At that size, full timeouts, the shortest and longest restart windows (25 and 32 ticks), and the exact restart-versus-timeout collision can all be reached in a few hundred cycles. A reference model in the bench predicts every interrupt cycle and feeds a scoreboard. The bench also measures the two restart-window extremes directly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTRL_W      = 8;
  localparam int EN_BIT      = 7;
  localparam int RESTART_BIT = 2;
  localparam int COARSE_W    = 2;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h80;

  function automatic bit is_valid_timeout(input longint unsigned t);
    return (t >= 8) && ((t & (t - 1)) == 0);
  endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic              enable,
  output logic              restart
);
  logic [CTRL_W-1:0] store_q;
  logic [CTRL_W-1:0] view;
  logic              wr_hit;

  assign wr_hit = sel && wr;

  genvar gi;
  generate
    for (gi = 0; gi < CTRL_W; gi++) begin : g_bit
      if (gi == RESTART_BIT) begin : g_cmd
        assign store_q[gi] = 1'b0;
        assign view[gi]    = 1'b0;
      end else begin : g_store
        always_ff @(posedge clk) begin
          if (rst)         store_q[gi] <= CTRL_RESET[gi];
          else if (wr_hit) store_q[gi] <= wdata[gi];
        end
        assign view[gi] = store_q[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (sel && rd) rdata <= view;
    else                rdata <= '0;
  end

  assign enable  = store_q[EN_BIT];
  assign restart = wr_hit && wdata[RESTART_BIT];

  a_r2_enable_follows_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (enable == $past(wdata[EN_BIT])));
  a_r11_no_select_no_change: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(store_q));
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int QUARTER = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic enable,
  output logic carry
);
  localparam int PW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [PW-1:0] LAST = PW'(QUARTER - 1);

  logic [PW-1:0] cnt_q;
  logic          step;

  assign step  = tick && enable;
  assign carry = step && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (step) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r9_prescaler_holds: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_coarse.sv
module wdog_coarse
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic carry,
  input  logic restart,
  input  logic enable,
  output logic nmi
);
  logic [COARSE_W-1:0] crs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_q <= '0;
      nmi   <= 1'b0;
    end else begin
      nmi <= 1'b0;
      if (restart) begin
        crs_q <= '0;
      end else if (carry) begin
        crs_q <= crs_q + 1'b1;
        if (crs_q == '1) nmi <= 1'b1;
      end
    end
  end

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (crs_q == '0));
  a_r10_restart_wins: assert property (@(posedge clk) disable iff (rst)
    restart |=> !nmi);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    nmi |=> !nmi);
  a_r9_coarse_holds: assert property (@(posedge clk) disable iff (rst)
    (!enable && !restart) |=> ($stable(crs_q) && !nmi));
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
  import wdog_pkg::*;
#(
  parameter longint unsigned TIMEOUT_TICKS = 131072
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       nmi_pulse
);
  localparam int QUARTER = int'(TIMEOUT_TICKS / 4);

  generate
    if (!is_valid_timeout(TIMEOUT_TICKS)) begin : g_bad_param
      $error("TIMEOUT_TICKS must be a power of two and at least 8");
    end
  endgenerate

  logic enable;
  logic restart;
  logic carry;

  wdog_ctrl_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .enable (enable),
    .restart(restart)
  );

  wdog_prescaler #(.QUARTER(QUARTER)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .enable(enable),
    .carry (carry)
  );

  wdog_coarse u_crs (
    .clk    (clk),
    .rst    (rst),
    .carry  (carry),
    .restart(restart),
    .enable (enable),
    .nmi    (nmi_pulse)
  );

  a_r5_nmi_needs_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_pulse) |-> $past(tick && enable));
endmodule

// File: tb/tb_wdog_unit.sv
module tb_wdog_unit;
  localparam int P = 32;
  localparam int Q = P / 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       nmi_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit seen_nmi;
  string cur_req = "R5";

  int unsigned exp_q[$];
  int m_pre = 0;
  int m_crs = 0;
  bit m_en  = 1;

  always #10 clk = ~clk;

  wdog_unit #(.TIMEOUT_TICKS(P)) dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_pulse(nmi_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares interrupt pulses with the expected queue
  always @(negedge clk) begin
    if (!rst) begin
      if (nmi_pulse) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
        end else begin
          errors++;
          $display("FAIL %s: unexpected interrupt at cycle %0d (actual 1, expected 0)", cur_req, cyc);
        end
      end
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s: missed interrupt due at cycle %0d (actual 0, expected 1)", cur_req, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  // Driver: applies one cycle of stimulus and steps the reference model
  task automatic drive(input bit t, input bit s, input bit w, input bit r, input logic [7:0] d);
    bit restart_w;
    bit carry;
    @(negedge clk);
    seen_nmi  = nmi_pulse;
    tick      = t;
    bus_sel   = s;
    bus_wr    = w;
    bus_rd    = r;
    bus_wdata = d;
    restart_w = s && w && d[2];
    carry = 0;
    if (t && m_en) begin
      carry = (m_pre == Q - 1);
      m_pre = (m_pre + 1) % Q;
    end
    if (restart_w) m_crs = 0;
    else if (carry) begin
      if (m_crs == 3) begin
        m_crs = 0;
        exp_q.push_back(cyc + 1);
      end else m_crs++;
    end
    if (s && w) m_en = d[7];
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 8'h00);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 8'h00);
    idle();
  endtask

  task automatic write_reg(input logic [7:0] d);
    drive(0, 1, 1, 0, d);
    idle();
  endtask

  task automatic read_check(input logic [7:0] exp, input string req);
    drive(0, 1, 0, 1, 8'h00);
    idle();
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read data actual %02h expected %02h", req, bus_rdata, exp);
    end
  endtask

  task automatic measure_restart(input int phase);
    int got;
    while (m_pre != phase) drive(1, 0, 0, 0, 8'h00);
    idle();
    write_reg(8'h84);
    got = -1;
    for (int k = 1; k <= P + 4; k++) begin
      drive(1, 0, 0, 0, 8'h00);
      idle();
      if (seen_nmi) begin
        got = k;
        break;
      end
    end
    checks++;
    if (got != P - phase) begin
      errors++;
      $display("FAIL R7: ticks from restart at phase %0d actual %0d expected %0d", phase, got, P - phase);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (nmi_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: interrupt after reset actual %b expected 0", nmi_pulse);
    end
    read_check(8'h80, "R1");

    // R5, R6: first and second full timeouts from reset
    cur_req = "R5";
    ticks(P);
    cur_req = "R6";
    ticks(P);
    ticks(3);

    // R2, R4, R3: register storage and write-only bit
    write_reg(8'h79);
    read_check(8'h79, "R2/R4 storage");
    write_reg(8'hFF);
    read_check(8'hFB, "R3 restart bit reads 0");
    write_reg(8'h80);
    read_check(8'h80, "R2 enable set");

    // R11: write without select ignored
    drive(0, 0, 1, 0, 8'h00);
    idle();
    read_check(8'h80, "R11 unselected write");

    // R9: disable holds, then resume
    cur_req = "R9";
    ticks(5);
    write_reg(8'h00);
    read_check(8'h00, "R2 enable cleared");
    ticks(3 * P);
    write_reg(8'h80);
    ticks(P + 5);

    // R7: restart window extremes
    cur_req = "R7";
    measure_restart(0);
    measure_restart(Q - 1);

    // R8: writing 0 to restart bit mid-count changes nothing
    cur_req = "R8";
    ticks(10);
    write_reg(8'h80);
    write_reg(8'h83);
    ticks(P + 3);

    // R10: restart and timeout in the same cycle
    cur_req = "R10";
    while (!(m_crs == 3 && m_pre == Q - 1)) drive(1, 0, 0, 0, 8'h00);
    drive(1, 1, 1, 0, 8'h84);
    idle();
    checks++;
    if (seen_nmi) begin
      errors++;
      $display("FAIL R10: interrupt on colliding restart actual 1 expected 0");
    end
    ticks(P + 2);

    repeat (4) idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6: pending expected interrupts actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule